// File: doc/BRIEF.md
# Bounds-Check Comparator with Condition Flags

This unit decides whether an operand value lies inside a lower/upper bound pair and reports the answer as an updated five-bit condition-flag word. One request carries the operand, both bounds, an operand size (byte, word or long), an operand-kind bit that marks the operand as a data value or an address, and the flag word currently held by the surrounding core. The unit widens every input to 32 bits before comparing. The bounds are always widened by sign extension from the selected size. A data operand is widened the same way. An address operand is always taken at its full 32 bits. The answer replaces only the zero and carry flags. The remaining three flags pass through unchanged.

The comparison uses two modular differences taken against the lower bound: the operand offset `d = v - lo` and the span `s = hi - lo`. The operand is in range when `d` does not exceed `s` as an unsigned number. Because both differences wrap modulo 2^32, a pair with `lo` above `hi` describes a range that wraps through zero.

Requests enter on a valid/ready interface and results leave on a second valid/ready interface, with one register stage between them. An input is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer at once. No request is dropped and none is duplicated. A presented result holds steady until `out_ready` takes it.

Top module: `bchk_unit`

## Requirements
- R1: With `in_size` = 2'b00 (byte), only bits [7:0] of each bound are used, and they are sign-extended to 32 bits. Bits [31:8] of the bounds have no effect on the result.
- R2: With `in_size` = 2'b01 (word), only bits [15:0] of each bound are used, and they are sign-extended to 32 bits. Bits [31:16] of the bounds have no effect on the result.
- R3: With `in_size` = 2'b10 or 2'b11 (long), the bounds and the operand are compared at their full 32 bits.
- R4: When `in_is_addr` = 0 (data operand), the operand is sign-extended from the selected size in the same way as the bounds. When `in_is_addr` = 1 (address operand), all 32 operand bits are used with no extension.
- R5: The zero flag (bit 2 of `out_flags`) is 1 exactly when the widened operand equals the widened lower bound or the widened upper bound.
- R6: The carry flag (bit 0 of `out_flags`) is 1 exactly when (v - lo) mod 2^32 is greater than (hi - lo) mod 2^32 as unsigned numbers, that is, when the operand is out of range. This definition covers wrapped ranges where lo > hi.
- R7: The flag word is laid out as bit 4 X, bit 3 N, bit 2 Z, bit 1 V, bit 0 C. Bits 4, 3 and 1 of the result equal the same bits of `in_flags` for that request.
- R8: `in_ready` equals `!out_valid || out_ready`. A request accepted on one edge is presented on `out_valid`/`out_flags` after that edge. While `out_valid` is 1 and `out_ready` is 0, `out_flags` holds its value and no new input is accepted.
- R9: While `rst_n` is low, `out_valid` and `out_flags` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_value | input | 32 | Operand to test |
| in_lo | input | 32 | Lower bound (low bits used for byte/word) |
| in_hi | input | 32 | Upper bound (low bits used for byte/word) |
| in_size | input | 2 | 00 byte, 01 word, 10/11 long |
| in_is_addr | input | 1 | 1: address operand, full width; 0: data operand, sign-extended |
| in_flags | input | 5 | Incoming flags {X,N,Z,V,C} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_flags | output | 5 | Updated flags {X,N,Z,V,C} |

## Verification
On every cycle, the embedded assertions check several properties. Equality with either bound must raise the zero flag, and equality with the lower bound must never raise the carry flag. An address operand must leave the extender untouched. A long size must leave the bounds untouched. The X, N and V bits must match the accepted request, and a stalled result must hold steady. Other behaviours can only be shown by the bench scenarios. These include the exact unsigned out-of-range decision on wrapped and sign-extended ranges, the effect of ignored upper bound bits, and the complete hand-off when a stalled result is drained while the next request is accepted on the same edge.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
  localparam int unsigned FLAG_W = 5;
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_V = 1;
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_N = 3;
  localparam int unsigned FLG_X = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_ALT  = 2'b11
  } opsize_e;

  localparam int unsigned N_OPS  = 3;
  localparam int unsigned OP_VAL = 0;
  localparam int unsigned OP_LO  = 1;
  localparam int unsigned OP_HI  = 2;
endpackage

// File: rtl/bchk_extend.sv
module bchk_extend
  import bchk_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw_i,
  input  opsize_e           size_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] wide_o
);
  localparam int unsigned BYTE_W = DATA_W / 4;
  localparam int unsigned WORD_W = DATA_W / 2;

  always_comb begin
    wide_o = raw_i;
    if (sext_i) begin
      unique case (size_i)
        SZ_BYTE: wide_o = {{(DATA_W-BYTE_W){raw_i[BYTE_W-1]}}, raw_i[BYTE_W-1:0]};
        SZ_WORD: wide_o = {{(DATA_W-WORD_W){raw_i[WORD_W-1]}}, raw_i[WORD_W-1:0]};
        default: wide_o = raw_i;
      endcase
    end
  end

  always_comb begin
    if (!sext_i) assert_addr_full_width_R4: assert (wide_o == raw_i);
    if (size_i == SZ_LONG || size_i == SZ_ALT)
      assert_long_unchanged_R3: assert (wide_o == raw_i);
  end
endmodule

// File: rtl/bchk_core.sv
module bchk_core
  import bchk_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] span;
  logic              hit_bound;
  logic              outside;

  assign offset    = val_i - lo_i;
  assign span      = hi_i - lo_i;
  assign hit_bound = (offset == '0) || (offset == span);
  assign outside   = (offset > span);

  always_comb begin
    flags_o        = flags_i;
    flags_o[FLG_Z] = hit_bound;
    flags_o[FLG_C] = outside;
  end

  always_comb begin
    if (val_i == lo_i) begin
      assert_z_on_low_R5: assert (flags_o[FLG_Z]);
      assert_low_in_range_R6: assert (!flags_o[FLG_C]);
    end
    if (val_i == hi_i) assert_z_on_high_R5: assert (flags_o[FLG_Z]);
  end
endmodule

// File: rtl/bchk_stage.sv
module bchk_stage #(
  parameter int unsigned PAY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_data
);
  logic             full_q;
  logic [PAY_W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end

  assert_hold_when_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));
  assert_empty_after_reset_R9: assert property (@(posedge clk)
    !rst_n |=> !dn_valid);
endmodule

// File: rtl/bchk_unit.sv
module bchk_unit
  import bchk_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_value,
  input  logic [DATA_W-1:0] in_lo,
  input  logic [DATA_W-1:0] in_hi,
  input  logic [1:0]        in_size,
  input  logic              in_is_addr,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLAG_W-1:0] out_flags
);
  logic [DATA_W-1:0] raw_op  [N_OPS];
  logic [DATA_W-1:0] wide_op [N_OPS];
  logic              sext_op [N_OPS];
  logic [FLAG_W-1:0] next_flags;
  opsize_e           size_e;

  assign size_e          = opsize_e'(in_size);
  assign raw_op[OP_VAL]  = in_value;
  assign raw_op[OP_LO]   = in_lo;
  assign raw_op[OP_HI]   = in_hi;
  assign sext_op[OP_VAL] = !in_is_addr;
  assign sext_op[OP_LO]  = 1'b1;
  assign sext_op[OP_HI]  = 1'b1;

  for (genvar g = 0; g < N_OPS; g++) begin : g_ext
    bchk_extend #(.DATA_W(DATA_W)) u_ext (
      .raw_i  (raw_op[g]),
      .size_i (size_e),
      .sext_i (sext_op[g]),
      .wide_o (wide_op[g])
    );
  end

  bchk_core #(.DATA_W(DATA_W)) u_core (
    .val_i   (wide_op[OP_VAL]),
    .lo_i    (wide_op[OP_LO]),
    .hi_i    (wide_op[OP_HI]),
    .flags_i (in_flags),
    .flags_o (next_flags)
  );

  bchk_stage #(.PAY_W(FLAG_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (next_flags),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_flags)
  );

  assert_keep_xnv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid
      && out_flags[FLG_X] == $past(in_flags[FLG_X])
      && out_flags[FLG_N] == $past(in_flags[FLG_N])
      && out_flags[FLG_V] == $past(in_flags[FLG_V])));
  assert_ready_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_bchk_unit.sv
`timescale 1ns/1ps
module test_bchk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_value = '0, in_lo = '0, in_hi = '0;
  logic [1:0]  in_size = '0;
  logic        in_is_addr = 1'b0;
  logic [4:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bchk_unit i_bchk_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_lo(in_lo), .in_hi(in_hi), .in_size(in_size),
    .in_is_addr(in_is_addr), .in_flags(in_flags), .out_valid(out_valid),
    .out_ready(out_ready), .out_flags(out_flags)
  );

  function automatic logic [31:0] widen(logic [31:0] v, logic [1:0] s, logic sx);
    if (!sx) return v;
    case (s)
      2'b00:   return {{24{v[7]}}, v[7:0]};
      2'b01:   return {{16{v[15]}}, v[15:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [4:0] model(logic [31:0] v, logic [31:0] lo, logic [31:0] hi,
                                       logic [1:0] s, logic ad, logic [4:0] f);
    logic [31:0] ev, el, eh, d, r;
    ev = widen(v, s, !ad);
    el = widen(lo, s, 1'b1);
    eh = widen(hi, s, 1'b1);
    d = ev - el;
    r = eh - el;
    return {f[4], f[3], (ev == el) || (ev == eh), f[1], d > r};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] v, lo, hi, input logic [1:0] s,
                       input logic ad, input logic [4:0] f);
    in_value = v; in_lo = lo; in_hi = hi; in_size = s; in_is_addr = ad; in_flags = f;
    in_valid = 1'b1;
  endtask

  task automatic send(input string tag, input logic [31:0] v, lo, hi,
                      input logic [1:0] s, input logic ad, input logic [4:0] f);
    @(negedge clk);
    drive(v, lo, hi, s, ad, f);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check(tag, {27'd0, out_flags}, {27'd0, model(v, lo, hi, s, ad, f)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [4:0] exp_a;
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R9 out_flags in reset", {27'd0, out_flags}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 ready when empty", {31'd0, in_ready}, 32'd1);

    // R1: byte bounds, upper bits ignored
    send("R1 byte in range", 32'hFFFFFF05, 32'h123456F0, 32'hABCDEF10, 2'b00, 1'b0, 5'b00000);
    check("R1 byte upper bits ignored", {27'd0, out_flags}, {27'd0, 5'b00000});
    send("R5 byte equals low", 32'hAB0000F0, 32'h000000F0, 32'h00000010, 2'b00, 1'b0, 5'b00000);
    check("R5 z on low", {31'd0, out_flags[2]}, 32'd1);
    // R4: address operand full width, 0xF0 is outside [-16,16]
    send("R4 address no extension", 32'h000000F0, 32'h000000F0, 32'h00000010, 2'b00, 1'b1, 5'b00000);
    check("R4 address out of range c", {31'd0, out_flags[0]}, 32'd1);
    // R2: word
    send("R2 word in range", 32'h12340000, 32'hFFFF8000, 32'h55557FFF, 2'b01, 1'b0, 5'b00000);
    send("R5 word equals high", 32'h00007FFF, 32'h00008000, 32'h00007FFF, 2'b01, 1'b0, 5'b00000);
    check("R5 z on high", {31'd0, out_flags[2]}, 32'd1);
    // R3: long sizes
    send("R3 long above high", 32'h00000021, 32'h00000010, 32'h00000020, 2'b10, 1'b0, 5'b00000);
    check("R3 long c", {31'd0, out_flags[0]}, 32'd1);
    send("R3 alt long code", 32'h12340018, 32'h12340010, 32'h12340020, 2'b11, 1'b0, 5'b00000);
    check("R3 alt long in range c", {31'd0, out_flags[0]}, 32'd0);
    // R6: wrapped range
    send("R6 wrapped inside", 32'h00000005, 32'hFFFFFFF0, 32'h00000010, 2'b10, 1'b0, 5'b00000);
    check("R6 wrapped inside c", {31'd0, out_flags[0]}, 32'd0);
    send("R6 wrapped outside", 32'h00000011, 32'hFFFFFFF0, 32'h00000010, 2'b10, 1'b0, 5'b00000);
    check("R6 wrapped outside c", {31'd0, out_flags[0]}, 32'd1);
    // R7: pass-through of X N V, incoming Z/C overwritten
    send("R7 flags pass", 32'h00000050, 32'h00000010, 32'h00000020, 2'b10, 1'b0, 5'b11111);
    check("R7 xnv kept", {27'd0, out_flags}, {27'd0, 5'b11011});
    send("R7 flags clear", 32'h00000015, 32'h00000010, 32'h00000020, 2'b10, 1'b1, 5'b00100);
    check("R7 all clear", {27'd0, out_flags}, {27'd0, 5'b00000});

    // R8: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(32'h00000030, 32'h00000010, 32'h00000020, 2'b10, 1'b0, 5'b01000);
    exp_a = model(32'h00000030, 32'h00000010, 32'h00000020, 2'b10, 1'b0, 5'b01000);
    @(negedge clk);
    check("R8 result presented", {31'd0, out_valid}, 32'd1);
    check("R8 stalled not ready", {31'd0, in_ready}, 32'd0);
    drive(32'h00000010, 32'h00000010, 32'h00000020, 2'b10, 1'b0, 5'b10010);
    @(negedge clk);
    check("R8 held flags", {27'd0, out_flags}, {27'd0, exp_a});
    check("R8 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    #1;
    check("R8 ready on drain", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    check("R8 next result", {27'd0, out_flags},
          {27'd0, model(32'h00000010, 32'h00000010, 32'h00000020, 2'b10, 1'b0, 5'b10010)});
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 drained empty", {31'd0, out_valid}, 32'd0);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v, lo, hi;
      logic [1:0] s;
      logic ad;
      logic [4:0] f;
      string tag;
      lo = $urandom; hi = $urandom; s = 2'($urandom); ad = 1'($urandom); f = 5'($urandom);
      case ($urandom % 4)
        0: v = lo;
        1: v = hi;
        2: v = lo + ($urandom % 8);
        default: v = $urandom;
      endcase
      if (ad) tag = "R4 random address";
      else if (s == 2'b00) tag = "R1 random byte";
      else if (s == 2'b01) tag = "R2 random word";
      else tag = "R3 random long";
      send(tag, v, lo, hi, s, ad, f);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule